// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counting Timer

This block gives a subsystem several independent down-counting timers. All of them advance on one shared tick. A single prescaler decrements on every clock cycle. When it passes zero it reloads from its own reload register and produces a tick that lasts one cycle. Each timer that is enabled counts down once per tick.

When a timer passes zero it either reloads from its reload register or stops, depending on its mode. If its interrupt is enabled, it also latches a sticky pending flag and sends a one-cycle pulse to an interrupt line. Software configures and observes the timers through a simple APB-style register port. A read-only configuration word lets software find the number of timers, the first interrupt number, and whether each timer drives its own line.

The registers are 32-bit words at byte addresses. The global slot sits at 0x00. Timer n sits in the slot at 0x10 + 16·n. Within a slot, word 0 holds the value, word 1 holds the reload and word 2 holds the control or configuration.

Top module: `pst_timer_unit`

## Requirements
- R1: After a synchronous active-low reset, every timer control word, counter and reload value reads 0. The prescaler reload reads PRE_MIN (default 2).
- R2: The word at 0x08 reads {23'b0, separate-lines flag in bit 8, IRQ_BASE in bits 7:3, NUM_TMR in bits 2:0}. The defaults give 0x123; shared-line mode with base 2 gives 0x13.
- R3: The prescaler decrements every cycle and reloads when it is at zero, which makes its period reload+1 cycles. A write to 0x00 sets its value, so a read two cycles after writing W returns W-1. A reload write below PRE_MIN at 0x04 stores PRE_MIN.
- R4: A timer with enable (control bit 0) set decrements once per tick. With auto-reload (bit 1) set, it passes zero every (reload+1)·(prescaler reload+1) cycles.
- R5: With enable cleared, the counter value does not change.
- R6: With bit 1 clear, passing zero leaves the counter at 0 and clears enable.
- R7: Writing 1 to control bit 2 copies the reload value into the counter. That bit always reads 0.
- R8: Passing zero with interrupt enable (bit 3) set sets the sticky pending bit (bit 4) and gives a one-cycle interrupt pulse. With bit 3 clear, neither the bit nor the pulse appears.
- R9: Writing 1 to bit 4 clears the pending bit. If that write lands in the same cycle as a zero-crossing, the pending bit stays set.
- R10: With separate lines selected, timer n pulses irq_o[IRQ_BASE+n]. Otherwise every timer pulses irq_o[IRQ_BASE].
- R11: Offset 0x0C of any slot, and any slot above NUM_TMR, reads 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq_o | output | IRQ_W (16) | Interrupt pulses |

## Verification
The hardest case to reach is a pending-clear write that lands in the exact cycle a timer crosses zero. Only the resolution of the set/clear collision tells the correct design apart from a faulty one. The stimulus forces the alignment through the prescaler value register. Write accesses issued back to back take effect two cycles apart. The bench therefore loads the prescaler with 1 and then writes a control word that clears pending and disables the timer, so the tick falls in the write's own cycle. Disabling in the same write stops later crossings from setting the flag again, so the read-back shows only the collision's outcome.

// File: rtl/pst_pkg.sv
// Package: control-word bit positions and slot-offset codes shared by the
// timer unit. Assumes 32-bit word addressing with 16-byte slots.
package pst_pkg;
    localparam int CB_EN = 0;  // count enable
    localparam int CB_RL = 1;  // auto-reload at zero
    localparam int CB_LD = 2;  // load command, self-clearing
    localparam int CB_IE = 3;  // interrupt enable
    localparam int CB_IP = 4;  // sticky pending

    typedef enum logic [1:0] {
        OFS_VAL  = 2'd0,
        OFS_RLD  = 2'd1,
        OFS_CTL  = 2'd2,
        OFS_NONE = 2'd3
    } ofs_e;
endpackage

// File: rtl/pst_prescaler.sv
// Shared prescaler: decrements every cycle and reloads at zero, emitting a
// one-cycle tick. Assumes PRE_MIN >= 1 so ticks are at least two cycles apart.
module pst_prescaler #(
    parameter int PRE_W   = 8,
    parameter int PRE_MIN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_we,
    input  logic             rld_we,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] cnt_o,
    output logic [PRE_W-1:0] rld_o,
    output logic             tick_o
);
    localparam logic [PRE_W-1:0] MIN_V = PRE_W'(PRE_MIN);

    logic [PRE_W-1:0] cnt_q, rld_q;

    // Reload register with lower clamp, and the decrementing value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= MIN_V;
        end else begin
            if (rld_we) rld_q <= (wdata < MIN_V) ? MIN_V : wdata;
            if (val_we)           cnt_q <= wdata;
            else if (cnt_q == '0) cnt_q <= rld_q;
            else                  cnt_q <= cnt_q - 1'b1;
        end
    end

    // Tick while the value sits at zero, unless software overwrites it.
    always_comb tick_o = (cnt_q == '0) && !val_we;

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;

    AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt_q == $past(rld_q)); // R3
    AST_RLD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        rld_q >= MIN_V); // R3
endmodule

// File: rtl/pst_channel.sv
// One timer channel: counter, reload and control state stepped by the shared
// tick. Assumes CNT_W >= 5 so the control bits fit in the write data.
module pst_channel
    import pst_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_we,
    input  logic             rld_we,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] rld_o,
    output logic [4:0]       ctl_o,
    output logic             fire_o
);
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic en_q, rl_q, ie_q, ip_q, fire_q;
    logic ld_cmd, uf, ip_clr;

    // Decode commands and detect a zero-crossing that is not overridden.
    always_comb begin
        ld_cmd = ctl_we && wdata[CB_LD];
        ip_clr = ctl_we && wdata[CB_IP];
        uf     = tick && en_q && (cnt_q == '0) && !cnt_we && !ld_cmd;
    end

    // Counter and reload value; a software write beats load, load beats tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            if (rld_we) rld_q <= wdata;
            if (cnt_we)      cnt_q <= wdata;
            else if (ld_cmd) cnt_q <= rld_q;
            else if (tick && en_q) begin
                if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
                else if (rl_q)   cnt_q <= rld_q;
            end
        end
    end

    // Control bits, sticky pending with set priority, interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rl_q   <= 1'b0;
            ie_q   <= 1'b0;
            ip_q   <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            if (ctl_we) begin
                en_q <= wdata[CB_EN];
                rl_q <= wdata[CB_RL];
                ie_q <= wdata[CB_IE];
            end else if (uf && !rl_q) begin
                en_q <= 1'b0;
            end
            ip_q   <= (ip_q && !ip_clr) || (uf && ie_q);
            fire_q <= uf && ie_q;
        end
    end

    assign cnt_o  = cnt_q;
    assign rld_o  = rld_q;
    assign ctl_o  = {ip_q, ie_q, 1'b0, rl_q, en_q};
    assign fire_o = fire_q;

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && !cnt_we && !ld_cmd |=> $stable(cnt_q)); // R5
    AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        uf && ie_q |=> ip_q && fire_o); // R9
    AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        uf && !rl_q && !ctl_we |=> !en_q && cnt_q == '0); // R6
endmodule

// File: rtl/pst_timer_unit.sv
// Timer unit top: register decode, read mux, shared prescaler, NUM_TMR
// channels and interrupt routing. Assumes 1 <= NUM_TMR <= 7, PRE_W <= CNT_W,
// and IRQ_BASE + NUM_TMR <= IRQ_W. Reads are combinational; a write occurs in
// the access phase (psel && penable && pwrite).
module pst_timer_unit
    import pst_pkg::*;
#(
    parameter int NUM_TMR  = 3,
    parameter int CNT_W    = 16,
    parameter int PRE_W    = 8,
    parameter int PRE_MIN  = 2,
    parameter int IRQ_BASE = 4,
    parameter int SEP_IRQ  = 1,
    parameter int IRQ_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [7:0]       paddr,
    input  logic [31:0]      pwdata,
    output logic [31:0]      prdata,
    output logic [IRQ_W-1:0] irq_o
);
    localparam logic [31:0] CFG_WORD =
        {23'd0, 1'(SEP_IRQ), 5'(IRQ_BASE), 3'(NUM_TMR)};

    logic             wr;
    logic [3:0]       slot;
    ofs_e             ofs;
    logic             tick;
    logic [PRE_W-1:0] pre_cnt, pre_rld;
    logic [CNT_W-1:0] cnt_a [NUM_TMR];
    logic [CNT_W-1:0] rld_a [NUM_TMR];
    logic [4:0]       ctl_a [NUM_TMR];
    logic [NUM_TMR-1:0] fire_v;
    logic             unused_bits;

    // Split the address into slot and word offset.
    always_comb begin
        wr   = psel && penable && pwrite;
        slot = paddr[7:4];
        ofs  = ofs_e'(paddr[3:2]);
    end

    assign unused_bits = ^{pwdata[31:CNT_W], paddr[1:0]};

    pst_prescaler #(.PRE_W(PRE_W), .PRE_MIN(PRE_MIN)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .val_we (wr && slot == 4'd0 && ofs == OFS_VAL),
        .rld_we (wr && slot == 4'd0 && ofs == OFS_RLD),
        .wdata  (pwdata[PRE_W-1:0]),
        .cnt_o  (pre_cnt),
        .rld_o  (pre_rld),
        .tick_o (tick)
    );

    for (genvar n = 0; n < NUM_TMR; n++) begin : g_ch
        pst_channel #(.CNT_W(CNT_W)) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .cnt_we (wr && slot == 4'(n + 1) && ofs == OFS_VAL),
            .rld_we (wr && slot == 4'(n + 1) && ofs == OFS_RLD),
            .ctl_we (wr && slot == 4'(n + 1) && ofs == OFS_CTL),
            .wdata  (pwdata[CNT_W-1:0]),
            .cnt_o  (cnt_a[n]),
            .rld_o  (rld_a[n]),
            .ctl_o  (ctl_a[n]),
            .fire_o (fire_v[n])
        );
    end

    // Read mux: global slot, then timer slots; everything else reads zero.
    always_comb begin
        prdata = '0;
        if (slot == 4'd0) begin
            case (ofs)
                OFS_VAL: prdata = 32'(pre_cnt);
                OFS_RLD: prdata = 32'(pre_rld);
                OFS_CTL: prdata = CFG_WORD;
                default: prdata = '0;
            endcase
        end
        for (int n = 0; n < NUM_TMR; n++) begin
            if (slot == 4'(n + 1)) begin
                case (ofs)
                    OFS_VAL: prdata = 32'(cnt_a[n]);
                    OFS_RLD: prdata = 32'(rld_a[n]);
                    OFS_CTL: prdata = 32'(ctl_a[n]);
                    default: prdata = '0;
                endcase
            end
        end
    end

    if (SEP_IRQ != 0) begin : g_sep
        // Route each channel pulse to its own line.
        always_comb begin
            irq_o = '0;
            for (int n = 0; n < NUM_TMR; n++) irq_o[IRQ_BASE+n] = fire_v[n];
        end
    end else begin : g_shr
        // Merge all channel pulses onto the base line.
        always_comb begin
            irq_o = '0;
            irq_o[IRQ_BASE] = |fire_v;
        end
    end

    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |=> !(|irq_o)); // R8
endmodule

// File: tb/test_pst_timer_unit.sv
module test_pst_timer_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int line;
        int gap;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel_m = 1'b0, psel_s = 1'b0;
    logic        penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata_m, prdata_s;
    logic [15:0] irq_m, irq_s;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pst_timer_unit i_pst_timer_unit (
        .clk(clk), .rst_n(rst_n), .psel(psel_m), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata_m), .irq_o(irq_m)
    );

    pst_timer_unit #(.SEP_IRQ(0), .IRQ_BASE(2)) i_pst_timer_unit_shr (
        .clk(clk), .rst_n(rst_n), .psel(psel_s), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata_s), .irq_o(irq_s)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic push_irq(input int line, input int gap);
        exp_t e;
        e.line = line;
        e.gap  = gap;
        sb_q.push_back(e);
    endtask

    // Monitor: pops expected pulses and compares line and spacing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && irq_m != '0) begin
            if (sb_q.size() == 0) begin
                chk("R8 unexpected pulse", 32'(irq_m), 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R10 line", 32'(irq_m), 32'(1) << e.line);
                if (e.gap != 0) chk("R4 period", 32'(cyc - last_cyc), 32'(e.gap));
                last_cyc = cyc;
            end
        end
    end

    task automatic bus_wr(input bit shr, input logic [7:0] a, input logic [31:0] d);
        paddr = a; pwdata = d; pwrite = 1'b1;
        if (shr) psel_s = 1'b1; else psel_m = 1'b1;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        @(posedge clk); @(negedge clk);
        psel_m = 1'b0; psel_s = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input bit shr, input logic [7:0] a, output logic [31:0] d);
        paddr = a; pwrite = 1'b0;
        if (shr) psel_s = 1'b1; else psel_m = 1'b1;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        #1 d = shr ? prdata_s : prdata_m;
        @(posedge clk); @(negedge clk);
        psel_m = 1'b0; psel_s = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input bit shr, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_rd(shr, a, d);
        chk(tag, d, exp);
    endtask

    task automatic drain(input int limit);
        for (int i = 0; i < limit && sb_q.size() != 0; i++) @(negedge clk);
        chk("scoreboard drained", 32'(sb_q.size()), 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v1, v2;
        bit seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 pre reload", 0, 8'h04, 32'd2);
        for (int n = 0; n < 3; n++) begin
            rd_chk("R1 ctrl", 0, 8'(8'h18 + 16*n), 32'h0);
            rd_chk("R1 cnt",  0, 8'(8'h10 + 16*n), 32'h0);
            rd_chk("R1 rld",  0, 8'(8'h14 + 16*n), 32'h0);
        end
        // R2 configuration word
        rd_chk("R2 cfg sep", 0, 8'h08, 32'h123);
        rd_chk("R2 cfg shr", 1, 8'h08, 32'h13);

        // R3 clamp and value write
        bus_wr(0, 8'h04, 32'h0);
        rd_chk("R3 clamp", 0, 8'h04, 32'd2);
        bus_wr(0, 8'h04, 32'd4);
        rd_chk("R3 reload", 0, 8'h04, 32'd4);
        bus_wr(0, 8'h00, 32'h40);
        rd_chk("R3 value decrements", 0, 8'h00, 32'h3F);

        // R11 unused and absent slots
        rd_chk("R11 unused global", 0, 8'h0C, 32'h0);
        bus_wr(0, 8'h1C, 32'hFFFF);
        bus_wr(0, 8'h40, 32'hFFFF);
        rd_chk("R11 absent slot", 0, 8'h40, 32'h0);
        rd_chk("R11 ctrl0 untouched", 0, 8'h18, 32'h0);
        rd_chk("R11 rld0 untouched", 0, 8'h14, 32'h0);

        // R4 auto-reload period: (3+1)*(4+1) = 20 cycles on line 4
        bus_wr(0, 8'h14, 32'd3);
        push_irq(4, 0); push_irq(4, 20); push_irq(4, 20);
        bus_wr(0, 8'h18, 32'h0F);
        drain(200);
        bus_wr(0, 8'h18, 32'h00);
        rd_chk("R8 sticky pending", 0, 8'h18, 32'h10);
        // R5 hold while disabled
        bus_rd(0, 8'h10, v1);
        repeat (30) @(negedge clk);
        bus_rd(0, 8'h10, v2);
        chk("R5 counter held", v2, v1);
        // R9 clear by writing 1
        bus_wr(0, 8'h18, 32'h10);
        rd_chk("R9 cleared", 0, 8'h18, 32'h0);

        // R6 one-shot on timer1, line 5
        bus_wr(0, 8'h24, 32'd2);
        push_irq(5, 0);
        bus_wr(0, 8'h28, 32'h0D);
        drain(200);
        repeat (40) @(negedge clk);
        rd_chk("R6 one-shot ctrl", 0, 8'h28, 32'h18);
        rd_chk("R6 one-shot cnt", 0, 8'h20, 32'h0);

        // R8 no pending or pulse with interrupt disabled; R7 load reads 0
        bus_wr(0, 8'h34, 32'd1);
        bus_wr(0, 8'h38, 32'h07);
        repeat (30) @(negedge clk);
        rd_chk("R8/R7 ie off ctrl", 0, 8'h38, 32'h03);
        bus_wr(0, 8'h38, 32'h00);
        bus_wr(0, 8'h34, 32'h1234);
        bus_wr(0, 8'h38, 32'h04);
        rd_chk("R7 load copied", 0, 8'h30, 32'h1234);
        rd_chk("R7 load bit reads 0", 0, 8'h38, 32'h0);

        // R9 set wins over a clear in the same cycle, timer2 line 6
        bus_wr(0, 8'h34, 32'h0);
        bus_wr(0, 8'h30, 32'h0);
        bus_wr(0, 8'h04, 32'd9);
        push_irq(6, 0);
        bus_wr(0, 8'h00, 32'd9);
        bus_wr(0, 8'h38, 32'h0B);
        bus_wr(0, 8'h00, 32'd1);
        bus_wr(0, 8'h38, 32'h1A);
        rd_chk("R9 set wins", 0, 8'h38, 32'h1A);
        drain(20);

        // R10 shared line: timer2 of the shared instance pulses line 2 only
        bus_wr(1, 8'h34, 32'd1);
        bus_wr(1, 8'h38, 32'h0D);
        seen = 1'b0;
        for (int i = 0; i < 50 && !seen; i++) begin
            @(negedge clk);
            if (irq_s != '0) begin
                seen = 1'b1;
                chk("R10 shared line", 32'(irq_s), 32'h4);
            end
        end
        chk("R10 shared pulse seen", 32'(seen), 32'h1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule